// File: doc/BRIEF.md
# Serial DAC Frame Transmitter

This block sends a 24-bit word to a 16-bit serial DAC over three wires: an active-low chip select, a serial clock and a data line. The host writes a 32-bit control word to register 0 of a small four-register window. The block builds the frame from three fields of that word. The 4-bit command comes from bits 3:0. Four zero padding bits follow. The 16-bit sample comes from bits 31:16. Bits 15:4 of the word are not used.

The serial clock is derived by counting system clock cycles. Each serial bit lasts exactly `CLKS_PER_BIT` system clocks. The first half of each bit has the serial clock low and the second half has it high. The DAC samples data on the rising edge, and data only changes on the falling edge. Chip select brackets exactly one frame. After each frame, chip select is held high for one full bit period before the next frame can start.

A write that arrives while a frame is running is held in a single pending slot. It is sent as soon as the current frame and its guard gap are over. A `busy` output tells the host when a transfer is in progress.

Top module: `dac_frame_tx`

## Requirements
- R1: After reset, `dac_cs_n` is 1, `dac_sclk` is 0, `dac_sdi` is 0 and `busy` is 0.
- R2: The frame is 24 bits, sent most significant first. Frame bit 23 down to bit 20 carry host word bits 3,2,1,0 in that order. Frame bits 19:16 are sent as 0. Frame bits 15:0 carry host word bits 31 down to 16, so bit 31 is sent first. Host word bits 15:4 never appear on the line.
- R3: Each frame bit stays on `dac_sdi` for exactly `CLKS_PER_BIT` (default 20) system clocks, the first bit included. `dac_sdi` does not change while `dac_sclk` is high.
- R4: In each bit, `dac_sclk` is low for the first `CLKS_PER_BIT/2` clocks and high for the remaining `CLKS_PER_BIT/2`, so it rises in mid-bit and falls at the bit boundary.
- R5: `dac_cs_n` falls in the same cycle that the first frame bit appears, half a bit before the first rising edge. It stays low for exactly 24 × `CLKS_PER_BIT` clocks and rises with the final falling edge of `dac_sclk`.
- R6: Once `dac_cs_n` rises, it stays high for at least `CLKS_PER_BIT` clocks before the next frame.
- R7: When the block is idle, a write to address 0 starts a frame. `dac_cs_n` goes low in the cycle after the write is sampled. `busy` is 1 from that cycle until the guard gap after the last frame ends, and it is 1 whenever `dac_cs_n` is 0.
- R8: A write to address 0 during a frame or its gap is held and sent right after that gap. If several writes arrive before it starts, only the most recent one is sent.
- R9: Writes to addresses 1, 2 and 3 have no effect. They start no frame and do not set `busy`, whether the block is idle or busy.
- R10: While `dac_cs_n` is high, `dac_sclk` and `dac_sdi` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe, one cycle per write |
| host_addr | input | 2 | Register index of the write |
| host_wdata | input | 32 | Write data; bits 3:0 are the command, bits 31:16 are the sample |
| dac_cs_n | output | 1 | Active-low DAC chip select |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_sdi | output | 1 | Serial data to the DAC |
| busy | output | 1 | High while a frame or its guard gap is in progress |

## Verification
The bound checker watches the line protocol on every cycle:
- the serial clock and data stay quiet while chip select is high;
- data holds steady during each high phase of the clock;
- each low and high half-phase has the right length;
- chip select stays low for exactly the frame length;
- the guard gap before each new frame is long enough;
- `busy` covers every low chip-select cycle.

The checker cannot see which bits go out or which host write they came from. Only the bench scenarios show that:
- the fields of the word map to the right frame bits;
- the padding bits are sent as zeros;
- a pending write gets overwritten by a later one;
- writes to the other addresses are dropped.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

    localparam int WORD_W      = 32;
    localparam int CMD_W       = 4;
    localparam int PAD_W       = 4;
    localparam int SAMPLE_W    = 16;
    localparam int FRAME_W     = CMD_W + PAD_W + SAMPLE_W;
    localparam int CMD_LSB     = 0;
    localparam int SAMPLE_LSB  = 16;
    localparam int REG_ADDR_W  = 2;
    localparam int BIT_IDX_W   = $clog2(FRAME_W);
    localparam logic [REG_ADDR_W-1:0] DAC_REG_IDX = '0;

    // Field order inside the frame is the order on the wire (MSB first).
    typedef struct packed {
        logic [CMD_W-1:0]    cmd;
        logic [PAD_W-1:0]    pad;
        logic [SAMPLE_W-1:0] sample;
    } dac_frame_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } tx_state_e;

    function automatic dac_frame_t pack_frame(input logic [WORD_W-1:0] word);
        dac_frame_t f;
        f.cmd    = word[CMD_LSB +: CMD_W];
        f.pad    = '0;
        f.sample = word[SAMPLE_LSB +: SAMPLE_W];
        return f;
    endfunction

endpackage

// File: rtl/dac_tx_phase.sv
// Counts system clocks inside one serial bit period.
module dac_tx_phase #(
    parameter int CLKS_PER_BIT = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic bit_end,
    output logic high_half
);
    localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CLKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(CLKS_PER_BIT / 2);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST_CNT) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign bit_end   = run && (cnt == LAST_CNT);
    assign high_half = run && (cnt >= HALF_CNT);

endmodule

// File: rtl/dac_tx_shifter.sv
// Frame shift register, MSB presented on the data line.
module dac_tx_shifter
    import dac_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  dac_frame_t load_frame,
    input  logic       shift,
    output logic       msb
);
    logic [FRAME_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (load) begin
            sr <= load_frame;
        end else if (shift) begin
            sr <= {sr[FRAME_W-2:0], 1'b0};
        end
    end

    assign msb = sr[FRAME_W-1];

endmodule

// File: rtl/dac_tx_ctrl.sv
// Sequencer: idle / shifting / guard gap, plus the single pending slot.
module dac_tx_ctrl
    import dac_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_hit,
    input  dac_frame_t wr_frame,
    input  logic       bit_end,
    output tx_state_e  state,
    output logic       load,
    output dac_frame_t load_frame,
    output logic       shift
);
    localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(FRAME_W - 1);

    tx_state_e            nxt_state;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic                 pend_valid;
    dac_frame_t           pend_frame;
    logic                 take_pend;
    logic                 last_bit;

    assign last_bit = (bit_idx == LAST_BIT);

    always_comb begin
        nxt_state  = state;
        load       = 1'b0;
        take_pend  = 1'b0;
        load_frame = wr_frame;
        unique case (state)
            ST_IDLE: begin
                if (wr_hit) begin
                    load      = 1'b1;
                    nxt_state = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (bit_end && last_bit) begin
                    nxt_state = ST_GAP;
                end
            end
            ST_GAP: begin
                if (bit_end) begin
                    if (pend_valid) begin
                        load       = 1'b1;
                        take_pend  = 1'b1;
                        load_frame = pend_frame;
                        nxt_state  = ST_SHIFT;
                    end else if (wr_hit) begin
                        load      = 1'b1;
                        nxt_state = ST_SHIFT;
                    end else begin
                        nxt_state = ST_IDLE;
                    end
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    assign shift = (state == ST_SHIFT) && bit_end && !last_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bit_idx    <= '0;
            pend_valid <= 1'b0;
            pend_frame <= '0;
        end else begin
            state <= nxt_state;
            if (load) begin
                bit_idx <= '0;
            end else if (shift) begin
                bit_idx <= bit_idx + 1'b1;
            end
            if (take_pend) begin
                pend_valid <= wr_hit;
                if (wr_hit) begin
                    pend_frame <= wr_frame;
                end
            end else if (wr_hit && !load) begin
                pend_valid <= 1'b1;
                pend_frame <= wr_frame;
            end
        end
    end

endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
    import dac_tx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 20
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_wr,
    input  logic [REG_ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0]     host_wdata,
    output logic                  dac_cs_n,
    output logic                  dac_sclk,
    output logic                  dac_sdi,
    output logic                  busy
);
    tx_state_e  state;
    dac_frame_t wr_frame;
    dac_frame_t load_frame;
    logic       wr_hit;
    logic       load;
    logic       shift;
    logic       bit_end;
    logic       high_half;
    logic       msb;
    logic       sending;

    assign wr_hit   = host_wr && (host_addr == DAC_REG_IDX);
    assign wr_frame = pack_frame(host_wdata);
    assign sending  = (state == ST_SHIFT);

    dac_tx_phase #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .run       (state != ST_IDLE),
        .bit_end   (bit_end),
        .high_half (high_half)
    );

    dac_tx_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_hit     (wr_hit),
        .wr_frame   (wr_frame),
        .bit_end    (bit_end),
        .state      (state),
        .load       (load),
        .load_frame (load_frame),
        .shift      (shift)
    );

    dac_tx_shifter u_shifter (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_frame (load_frame),
        .shift      (shift),
        .msb        (msb)
    );

    assign dac_cs_n = !sending;
    assign dac_sclk = sending && high_half;
    assign dac_sdi  = sending && msb;
    assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/dac_frame_tx_checker.sv
module dac_frame_tx_checker #(
    parameter int CLKS_PER_BIT = 20,
    parameter int FRAME_W      = 24
) (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sclk,
    input logic sdi,
    input logic busy
);
    localparam int CW = 16;
    localparam logic [CW-1:0] FRAME_CYC = CW'(FRAME_W * CLKS_PER_BIT);
    localparam logic [CW-1:0] HALF      = CW'(CLKS_PER_BIT / 2);
    localparam logic [CW-1:0] GAP_MIN   = CW'(CLKS_PER_BIT);
    localparam logic [CW-1:0] SAT       = '1;

    logic [CW-1:0] low_cnt;
    logic [CW-1:0] high_cnt;
    logic [CW-1:0] lo_run;
    logic [CW-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt  <= '0;
            high_cnt <= GAP_MIN;
            lo_run   <= '0;
            hi_run   <= '0;
        end else begin
            low_cnt  <= cs_n ? '0 : ((low_cnt == SAT) ? SAT : low_cnt + 1'b1);
            high_cnt <= !cs_n ? '0 : ((high_cnt == SAT) ? SAT : high_cnt + 1'b1);
            lo_run   <= (cs_n || sclk) ? '0 : lo_run + 1'b1;
            hi_run   <= !sclk ? '0 : hi_run + 1'b1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!sclk && !sdi)); // R10
    AST_SDI_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(sdi)); // R3
    AST_SCLK_LOW_PHASE: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> (lo_run == HALF)); // R4
    AST_SCLK_HIGH_PHASE: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> (hi_run == HALF)); // R4
    AST_CS_FRAME_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> (low_cnt == FRAME_CYC)); // R5
    AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (high_cnt >= GAP_MIN)); // R6
    AST_CS_UNDER_BUSY: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy); // R7

endmodule

bind dac_frame_tx dac_frame_tx_checker #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_dac_frame_tx_checker (
    .clk  (clk),
    .rst  (rst),
    .cs_n (dac_cs_n),
    .sclk (dac_sclk),
    .sdi  (dac_sdi),
    .busy (busy)
);

// File: tb/dac_frame_tx_bench.sv
module dac_frame_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CPB        = 20;
    localparam int HALF       = CPB / 2;
    localparam int FW         = 24;
    localparam int FRAME_CYC  = FW * CPB;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        dac_cs_n, dac_sclk, dac_sdi, busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dac_frame_tx #(.CLKS_PER_BIT(CPB)) u_dac_frame_tx (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .dac_cs_n   (dac_cs_n),
        .dac_sclk   (dac_sclk),
        .dac_sdi    (dac_sdi),
        .busy       (busy)
    );

    function automatic logic [FW-1:0] exp_frame(input logic [31:0] w);
        return {w[3], w[2], w[1], w[0], 4'b0000, w[31:16]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Called just after a negedge; drives one write cycle, returns at the next sample point.
    task automatic host_write(input logic [1:0] addr, input logic [31:0] data);
        host_wr    = 1'b1;
        host_addr  = addr;
        host_wdata = data;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // Entered at sample point k=0 of a frame; checks the frame and its gap cycle by cycle.
    // Up to two writes are injected at cycles inj1_k / inj2_k (-1 = none).
    task automatic check_frame(input logic [31:0] word,
                               input int inj1_k, input logic [1:0] a1, input logic [31:0] d1,
                               input int inj2_k, input logic [1:0] a2, input logic [31:0] d2);
        logic [FW-1:0] fr;
        int m_data, m_sclk, m_cs, m_gap, m_busy;
        logic [31:0] fa_data, fe_data, fa_sclk, fe_sclk;
        fr = exp_frame(word);
        m_data = 0; m_sclk = 0; m_cs = 0; m_gap = 0; m_busy = 0;
        fa_data = '0; fe_data = '0; fa_sclk = '0; fe_sclk = '0;
        for (int k = 0; k < FRAME_CYC + CPB; k++) begin
            if (k < FRAME_CYC) begin
                logic e_sdi, e_sclk;
                e_sdi  = fr[FW - 1 - k / CPB];
                e_sclk = ((k % CPB) >= HALF);
                if (dac_sdi !== e_sdi) begin
                    if (m_data == 0) begin fa_data = {31'd0, dac_sdi}; fe_data = {31'd0, e_sdi}; end
                    m_data++;
                end
                if (dac_sclk !== e_sclk) begin
                    if (m_sclk == 0) begin fa_sclk = {31'd0, dac_sclk}; fe_sclk = {31'd0, e_sclk}; end
                    m_sclk++;
                end
                if (dac_cs_n !== 1'b0) m_cs++;
            end else begin
                if (dac_cs_n !== 1'b1 || dac_sclk !== 1'b0 || dac_sdi !== 1'b0) m_gap++;
            end
            if (busy !== 1'b1) m_busy++;
            host_wr = 1'b0;
            if (k == inj1_k) begin host_wr = 1'b1; host_addr = a1; host_wdata = d1; end
            if (k == inj2_k) begin host_wr = 1'b1; host_addr = a2; host_wdata = d2; end
            @(negedge clk);
        end
        host_wr = 1'b0;
        check(m_data == 0, "R2/R3", "frame bit on sdi", fa_data, fe_data);
        check(m_sclk == 0, "R4", "sclk phase", fa_sclk, fe_sclk);
        check(m_cs == 0, "R5", "cs_n low over frame (mismatch cycles)", m_cs, 0);
        check(m_gap == 0, "R6/R10", "quiet lines in gap (mismatch cycles)", m_gap, 0);
        check(m_busy == 0, "R7", "busy during frame+gap (mismatch cycles)", m_busy, 0);
    endtask

    task automatic expect_idle(input string req);
        check(busy == 1'b0 && dac_cs_n == 1'b1, req, "idle after frame {busy,cs_n}",
              {30'd0, busy, dac_cs_n}, 32'h1);
    endtask

    task automatic t_reset;
        check(dac_cs_n == 1'b1 && dac_sclk == 1'b0 && dac_sdi == 1'b0 && busy == 1'b0,
              "R1", "reset {cs_n,sclk,sdi,busy}",
              {28'd0, dac_cs_n, dac_sclk, dac_sdi, busy}, 32'h8);
    endtask

    task automatic t_single(input logic [31:0] word);
        host_write(2'd0, word);
        check(dac_cs_n == 1'b0 && busy == 1'b1 && dac_sclk == 1'b0, "R5/R7",
              "start cycle {cs_n,busy,sclk}", {29'd0, dac_cs_n, busy, dac_sclk}, 32'h2);
        check_frame(word, -1, 2'd0, '0, -1, 2'd0, '0);
        expect_idle("R7");
    endtask

    task automatic t_ignored;
        int bad;
        bad = 0;
        host_write(2'd1, 32'hFFFF_000F);
        host_write(2'd2, 32'h1234_0003);
        host_write(2'd3, 32'hABCD_0005);
        for (int i = 0; i < 3 * CPB; i++) begin
            if (dac_cs_n !== 1'b1 || busy !== 1'b0 || dac_sclk !== 1'b0) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R9", "idle writes to addr 1..3 (active cycles)", bad, 0);
    endtask

    task automatic t_pending;
        // A is sent; B then C arrive during A; only C follows.
        host_write(2'd0, 32'h5A5A_0003);
        check_frame(32'h5A5A_0003, 100, 2'd0, 32'h1111_0001, 300, 2'd0, 32'hC3E7_0009);
        check_frame(32'hC3E7_0009, -1, 2'd0, '0, -1, 2'd0, '0);
        expect_idle("R8");
    endtask

    task automatic t_gap_write;
        // A write during the guard gap is sent straight after it.
        host_write(2'd0, 32'h0F0F_000C);
        check_frame(32'h0F0F_000C, FRAME_CYC + 5, 2'd0, 32'hF0F0_0006, -1, 2'd0, '0);
        check_frame(32'hF0F0_0006, -1, 2'd0, '0, -1, 2'd0, '0);
        expect_idle("R8");
    endtask

    task automatic t_busy_other_addr;
        // Writes to other addresses during a frame leave nothing pending.
        host_write(2'd0, 32'h8001_0003);
        check_frame(32'h8001_0003, 40, 2'd2, 32'hFFFF_FFFF, FRAME_CYC + 3, 2'd3, 32'h1234_5678);
        expect_idle("R9");
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single(32'hA5C3_0003);        // R2 default command 0011
        t_single(32'h1234_FFFA);        // R2 bits 15:4 set, padding must stay zero
        t_single(32'hFFFF_0000);        // R2 all-ones sample, zero command
        t_ignored();
        t_pending();
        t_gap_write();
        t_busy_other_addr();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule